// File: doc/BRIEF.md
# Pipelined SRAM Read Path with Selectable Deselect Timing

This block is the read side of a synchronous pipelined static RAM. Commands, the address and write data are registered on the rising clock edge. A read returns data through an output register, and an output-enable signal drives the external tristate. A short burst counter lets one start command be followed by advance commands that step through an aligned group of four words. A small behavioural array makes reads return the data that was written.

A configuration input chooses how fast the data bus is released after a deselect. In the late-release setting, a deselect travels down the same pipeline as a read, so the bus turns off two edges after capture (dual-cycle deselect). In the early-release setting, the bus turns off one edge after capture (single-cycle deselect). A write command releases the bus in the same way as a deselect. A snooze input stops all command processing and forces the bus off. It keeps the array contents.

Top module: `sram_read_pipe`

## Requirements
- R1: All inputs are sampled on the rising clock edge. While `rstN` is low, `outEn` is 0 and `rdData` is 0.
- R2: A read captured at edge k puts the word at its address on `rdData` and sets `outEn` to 1 at edge k+2, not at edge k+1.
- R3: A start with `wrIn`=1 stores `wrDataIn` from the same cycle at the captured address. A later read of that address returns it. Command priority is snooze, then deselect, then start, then advance.
- R4: An advance repeats the last started operation at the next address. The low 2 address bits increment and wrap inside the aligned group of four. A start plus three advances gives read data on cycles 3, 4, 5 and 6 (a 3-1-1-1 pattern).
- R5: A cycle with no command holds `outEn` and `rdData`. An advance with no active burst (after reset, a deselect or a snooze) acts as a cycle with no command.
- R6: With `fastRelease`=0, a deselect or write captured at edge k drives `outEn` to 0 at edge k+2.
- R7: With `fastRelease`=1, a deselect or write captured at edge k drives `outEn` to 0 at edge k+1. If a read lands at edge k+1, that read is shown for one cycle and `outEn` goes to 0 at edge k+2.
- R8: When `snoozeIn` is 1 at an edge, `outEn` is 0 after that edge. Commands in that cycle are ignored, reads in flight are dropped, the burst ends, and the array keeps its contents.
- R9: The command in the first cycle after `snoozeIn` returns to 0 is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| snoozeIn | input | 1 | Low-power hold; 1 ignores commands and turns the bus off |
| fastRelease | input | 1 | 1 = single-cycle deselect, 0 = dual-cycle deselect |
| deselIn | input | 1 | Deselect command |
| startIn | input | 1 | Start a new access at `addrIn` |
| advIn | input | 1 | Advance the current burst |
| wrIn | input | 1 | With `startIn`: 1 = write burst, 0 = read burst |
| addrIn | input | ADDR_W | Start address |
| wrDataIn | input | DATA_W | Write data for start and advance cycles of a write burst |
| rdData | output | DATA_W | Registered read data |
| outEn | output | 1 | Output enable for the data tristate |

## Verification
The bench checks that a read does not appear one edge early. A design that skipped the middle stage would raise `outEn` one cycle too soon. It runs a read, an idle cycle and a deselect under both release settings. A block that ignored the setting would release the bus at the same edge in both cases. It also runs a read followed at once by a deselect in early-release mode. This catches a design that lets the deselect hide the landing read, or one that leaves the bus driven afterwards. Snooze tests cover a write issued during snooze, which must not reach the array, and a read in flight when snooze begins, which must not appear after release. Burst tests start mid-group to catch address wrap that carries into the upper bits.

// File: rtl/sram_read_pkg.sv
package sram_read_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } opE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;     // commit registered write data to the array
    logic rdEn;     // fetch the array word into the middle stage
    logic loadOut;  // move the middle stage into the output register
  } strobeT;

  // commands that release the data bus
  function automatic logic releasesBus(opE op);
    return (op == OP_WRITE) || (op == OP_DESEL);
  endfunction

endpackage

// File: rtl/sram_read_ctrl.sv
module sram_read_ctrl
  import sram_read_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoozeIn,
  input  logic              fastRelease,
  input  logic              deselIn,
  input  logic              startIn,
  input  logic              advIn,
  input  logic              wrIn,
  input  logic [ADDR_W-1:0] addrIn,
  output strobeT            strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              outEn
);

  localparam int HI_W = ADDR_W - BURST_W;

  opE stA, stB, burstOp, newOp;
  logic [ADDR_W-1:0] addrA, nextAddr;
  logic advOk, offHit;

  assign advOk = advIn && (burstOp != OP_NOP);

  // command decode, priority deselect > start > advance
  always_comb begin
    newOp    = OP_NOP;
    nextAddr = addrA;
    if (deselIn) begin
      newOp = OP_DESEL;
    end else if (startIn) begin
      newOp    = wrIn ? OP_WRITE : OP_READ;
      nextAddr = addrIn;
    end else if (advOk) begin
      newOp    = burstOp;
      nextAddr = {addrA[ADDR_W-1:BURST_W], addrA[BURST_W-1:0] + BURST_W'(1)};
    end
  end

  // early release looks at the capture stage, late release at the second stage
  assign offHit = releasesBus(stB) || (fastRelease && releasesBus(stA));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stA     <= OP_NOP;
      stB     <= OP_NOP;
      burstOp <= OP_NOP;
      addrA   <= '0;
      outEn   <= 1'b0;
    end else if (snoozeIn) begin
      stA     <= OP_NOP;
      stB     <= OP_NOP;
      burstOp <= OP_NOP;
      outEn   <= 1'b0;
    end else begin
      stA   <= newOp;
      stB   <= stA;
      addrA <= nextAddr;
      if (deselIn)      burstOp <= OP_NOP;
      else if (startIn) burstOp <= newOp;
      if (stB == OP_READ) outEn <= 1'b1;
      else if (offHit)    outEn <= 1'b0;
    end
  end

  assign strobe.wrEn    = (stA == OP_WRITE);
  assign strobe.rdEn    = (stA == OP_READ);
  assign strobe.loadOut = (stB == OP_READ);
  assign memAddr        = addrA;

  // a read in the second stage lands on the bus at the next edge
  assert_read_lands_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stB == OP_READ && !snoozeIn) |=> outEn);

  // late release: a releasing command only in the capture stage changes nothing yet
  assert_late_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!fastRelease && !snoozeIn && releasesBus(stA) && stB == OP_NOP) |=> $stable(outEn));

  // early release: bus off one edge after capture unless a read lands
  assert_early_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fastRelease && !snoozeIn && releasesBus(stA) && stB != OP_READ) |=> !outEn);

  assert_snooze_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    snoozeIn |=> !outEn);

  // burst step increments the low bits and keeps the group
  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (advOk && !deselIn && !startIn && !snoozeIn) |=>
      (addrA[BURST_W-1:0] == $past(addrA[BURST_W-1:0]) + BURST_W'(1)) &&
      (addrA[ADDR_W-1:BURST_W] == $past(addrA[ADDR_W-1:BURST_W])));

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;

endmodule

// File: rtl/sram_read_dp.sv
module sram_read_dp
  import sram_read_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] wrDataIn,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wrQ, rdBuf;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[memAddr] <= wrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ    <= '0;
      rdBuf  <= '0;
      rdData <= '0;
    end else begin
      wrQ <= wrDataIn;
      if (strobe.rdEn)    rdBuf  <= mem[memAddr];
      if (strobe.loadOut) rdData <= rdBuf;
    end
  end

  // the registered write word is in the array one edge after the strobe
  assert_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> (mem[$past(memAddr)] == $past(wrQ)));

endmodule

// File: rtl/sram_read_pipe.sv
module sram_read_pipe
  import sram_read_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoozeIn,
  input  logic              fastRelease,
  input  logic              deselIn,
  input  logic              startIn,
  input  logic              advIn,
  input  logic              wrIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              outEn
);

  strobeT            strobe;
  logic [ADDR_W-1:0] memAddr;

  sram_read_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .snoozeIn(snoozeIn), .fastRelease(fastRelease),
    .deselIn(deselIn), .startIn(startIn), .advIn(advIn), .wrIn(wrIn),
    .addrIn(addrIn), .strobe(strobe), .memAddr(memAddr), .outEn(outEn)
  );

  sram_read_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memAddr(memAddr),
    .wrDataIn(wrDataIn), .rdData(rdData)
  );

  // reset state of the outputs
  always_ff @(posedge clk) begin
    if (!rstN) assert_reset_R1: assert (!outEn && rdData == '0);
  end

endmodule

// File: tb/test_sram_read_pipe.sv
module test_sram_read_pipe;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        snoozeIn = 1'b0, fastRelease = 1'b0, deselIn = 1'b0;
  logic        startIn = 1'b0, advIn = 1'b0, wrIn = 1'b0;
  logic [5:0]  addrIn = '0;
  logic [15:0] wrDataIn = '0;
  logic [15:0] rdData;
  logic        outEn;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sram_read_pipe i_sram_read_pipe (
    .clk(clk), .rstN(rstN), .snoozeIn(snoozeIn), .fastRelease(fastRelease),
    .deselIn(deselIn), .startIn(startIn), .advIn(advIn), .wrIn(wrIn),
    .addrIn(addrIn), .wrDataIn(wrDataIn), .rdData(rdData), .outEn(outEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set inputs at a falling edge, then pass one rising edge
  task automatic drive(input logic sn, ds, st, av, wr, input logic [5:0] a, input logic [15:0] d);
    snoozeIn = sn; deselIn = ds; startIn = st; advIn = av; wrIn = wr;
    addrIn = a; wrDataIn = d;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [5:0] a);  drive(0, 0, 1, 0, 0, a, 16'h0); endtask
  task automatic doWrite(input logic [5:0] a, input logic [15:0] d); drive(0, 0, 1, 0, 1, a, d); endtask
  task automatic doAdv(input logic [15:0] d);  drive(0, 0, 0, 1, 0, 6'd0, d); endtask
  task automatic doIdle();                     drive(0, 0, 0, 0, 0, 6'd0, 16'h0); endtask
  task automatic doDesel();                    drive(0, 1, 0, 0, 0, 6'd0, 16'h0); endtask

  task automatic tReset();
    chk("R1 outEn in reset", outEn, 0);
    chk("R1 rdData in reset", rdData, 0);
  endtask

  task automatic tSingle();
    fastRelease = 1'b0;
    doWrite(6'd5, 16'hA5A5);
    doIdle();
    doRead(6'd5);
    doIdle();
    chk("R2 no data one edge after capture", outEn, 0);
    doIdle();
    chk("R2 outEn two edges after capture", outEn, 1);
    chk("R3 written word read back", rdData, 16'hA5A5);
    doDesel(); doIdle(); doIdle();
  endtask

  task automatic tBurst();
    fastRelease = 1'b0;
    doWrite(6'd8, 16'h1111); doAdv(16'h2222); doAdv(16'h3333); doAdv(16'h4444);
    doDesel(); doIdle(); doIdle();
    doRead(6'd8); doAdv(16'h0);
    doAdv(16'h0);
    chk("R4 burst beat 1 enable", outEn, 1);
    chk("R4 burst beat 1", rdData, 16'h1111);
    doAdv(16'h0);
    chk("R4 burst beat 2", rdData, 16'h2222);
    doIdle();
    chk("R4 burst beat 3", rdData, 16'h3333);
    doIdle();
    chk("R4 burst beat 4", rdData, 16'h4444);
    // start mid-group: 10, 11, 8, 9
    doRead(6'd10); doAdv(16'h0);
    doAdv(16'h0);
    chk("R4 wrap beat 1", rdData, 16'h3333);
    doAdv(16'h0);
    chk("R4 wrap beat 2", rdData, 16'h4444);
    doIdle();
    chk("R4 wrap beat 3", rdData, 16'h1111);
    doIdle();
    chk("R4 wrap beat 4", rdData, 16'h2222);
    doIdle();
    chk("R5 idle holds data", rdData, 16'h2222);
    chk("R5 idle holds enable", outEn, 1);
    doDesel(); doIdle(); doIdle();
    chk("R6 bus off after burst", outEn, 0);
  endtask

  // read, idle, release command; compare release edge per setting
  task automatic tRelease(input logic fast, input logic useWrite);
    fastRelease = fast;
    doRead(6'd5);
    doIdle();
    if (useWrite) doWrite(6'd20, 16'h1234); else doDesel();
    chk("R2 read on bus before release", outEn, 1);
    doIdle();
    if (fast) chk("R7 early release after one edge", outEn, 0);
    else      chk("R6 late release still driven", outEn, 1);
    doIdle();
    chk(fast ? "R7 off after two edges" : "R6 off after two edges", outEn, 0);
    if (useWrite) begin
      doRead(6'd20); doIdle(); doIdle();
      chk("R3 write during release stored", rdData, 16'h1234);
      doDesel(); doIdle(); doIdle();
    end
  endtask

  task automatic tCollide(input logic fast);
    fastRelease = fast;
    doRead(6'd5);
    doDesel();
    chk("R7 bus off before read lands", outEn, 0);
    doIdle();
    chk("R7 landing read is shown", outEn, 1);
    chk("R7 landing read data", rdData, 16'hA5A5);
    doIdle();
    chk("R7 deselect applied next edge", outEn, 0);
  endtask

  task automatic tAdvNoBurst();
    fastRelease = 1'b0;
    doRead(6'd5); doIdle();
    doDesel();
    doAdv(16'h0);
    chk("R6 late release holds", outEn, 1);
    doIdle();
    chk("R6 off", outEn, 0);
    doIdle();
    chk("R5 advance after deselect is idle", outEn, 0);
  endtask

  task automatic tSnooze();
    fastRelease = 1'b0;
    doRead(6'd5); doIdle(); doIdle();
    chk("R2 on before snooze", outEn, 1);
    drive(1, 0, 1, 0, 1, 6'd5, 16'hDEAD);
    chk("R8 snooze turns bus off", outEn, 0);
    drive(1, 0, 0, 0, 0, 6'd0, 16'h0);
    chk("R8 bus stays off in snooze", outEn, 0);
    doRead(6'd5); doIdle(); doIdle();
    chk("R9 read right after release", outEn, 1);
    chk("R8 write in snooze ignored", rdData, 16'hA5A5);
    doRead(6'd8);
    drive(1, 0, 0, 0, 0, 6'd0, 16'h0);
    doIdle();
    chk("R8 in-flight read dropped", outEn, 0);
    doAdv(16'h0); doIdle(); doIdle();
    chk("R8 burst ended by snooze", outEn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tSingle();
    tBurst();
    tRelease(1'b0, 1'b0);
    tRelease(1'b1, 1'b0);
    tRelease(1'b0, 1'b1);
    tRelease(1'b1, 1'b1);
    tCollide(1'b1);
    tCollide(1'b0);
    tAdvNoBurst();
    tSnooze();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule